// File: doc/BRIEF.md
# Alpha-Weighted Video Pixel Mixer

This block blends two 24-bit pixel streams, A and B, one pixel per clock, under a 9-bit per-pixel weight. Each of the three 8-bit lanes in a pixel word is computed on its own as B plus weight/256 times (A − B), using the same weight for all three lanes. The result is rounded to the nearest code, and exact halves go upward. A weight of zero returns B, a weight of 0x100 returns A exactly, and larger codes act as 0x100. Each lane can be set to work on unsigned magnitudes (green, blue, red, luma) or on two's-complement values (the colour-difference components).

A three-way output selector puts input A, input B or the blended pixel on the output port. A pass-enable qualifier forces the output to B when it is low. An active-video qualifier travels with the pixel. The pixel data, the weight and all controls are sampled together on a rising clock edge. They come out after a fixed three-register pipeline, and both qualifiers are delayed by the same amount, so each pixel stays aligned with its flags. Both inputs must already be in the same colour format.

Top module: `alpha_pix_mixer`

## Requirements
- R1: Each lane result equals B + floor((w·(A − B) + 128) / 256), where w is the weight. An exact half therefore rounds upward. For example, B=0xEE, A=0xBB gives 0xE1 at w=0x040 and 0xD5 at w=0x080, and B=0xDD, A=0xAA gives 0xC4 at w=0x080.
- R2: A weight of 0x000 gives exactly B on every lane, and a weight of 0x100 gives exactly A on every lane.
- R3: Any weight code above 0x100 (0x101 to 0x1FF) gives the same result as 0x100.
- R4: The lanes are bits [7:0] (lane 0), [15:8] (lane 1) and [23:16] (lane 2). All three are blended with the same weight, and no lane's value affects any other lane.
- R5: When bit k of `lane_signed_i` is 1, lane k treats A and B as two's-complement values and limits its result to −128..+127. When the bit is 0, the lane treats them as unsigned and limits its result to 0..255.
- R6: `out_sel_i` selects the output source: 2'b00 gives the blended pixel, 2'b01 gives input A, 2'b10 gives input B, and 2'b11 also gives the blended pixel.
- R7: When pass-enable is low for a pixel, the output for that pixel is input B, whatever the weight and the selector are.
- R8: Inputs sampled at rising edge k appear on `pix_o`, `pass_en_o` and `act_vid_o` right after rising edge k+2. A new pixel is accepted on every clock.
- R9: While `rst_n` is low at a rising edge, `pix_o`, `pass_en_o` and `act_vid_o` are zero after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| pix_a_i | input | 24 | Pixel stream A, three 8-bit lanes |
| pix_b_i | input | 24 | Pixel stream B, three 8-bit lanes |
| alpha_i | input | 9 | Blend weight, 0x100 = full A |
| lane_signed_i | input | 3 | Per-lane two's-complement mode |
| out_sel_i | input | 2 | Output source select |
| pass_en_i | input | 1 | Pass-enable qualifier; low forces B |
| act_vid_i | input | 1 | Active-video qualifier |
| pix_o | output | 24 | Selected or blended pixel |
| pass_en_o | output | 1 | Pass-enable aligned with `pix_o` |
| act_vid_o | output | 1 | Active-video aligned with `pix_o` |

## Verification
Every result is due on the third rising edge, counting the edge that samples the stimulus. The pixel word and both aligned qualifiers arrive in that same cycle. The directed scenarios change their inputs on a falling edge, wait three rising edges, and compare on the next falling edge. The streaming scenario feeds a new pixel every clock and compares each output against the stimulus it drove three falling edges earlier. This shows both the exact delay and that a result is never overwritten by the pixel that follows it. The reset state is compared while reset is still held.

// File: rtl/amx_pkg.sv
// Shared types for the alpha pixel mixer.
// Assumes: the output select is a 2-bit field decoded only by the output stage.
package amx_pkg;

    // Output source select codes
    typedef enum logic [1:0] {
        SEL_BLEND  = 2'b00,
        SEL_SRC_A  = 2'b01,
        SEL_SRC_B  = 2'b10,
        SEL_BLEND2 = 2'b11
    } out_sel_e;

endpackage

// File: rtl/amx_capture.sv
// Input capture stage: registers pixel data, weight and controls on one edge.
// The weight is clamped to full scale before it is registered.
// Assumes: ALPHA_W >= 2; full scale is 1 << (ALPHA_W-1).
module amx_capture #(
    parameter int unsigned PIX_W   = 24,
    parameter int unsigned ALPHA_W = 9,
    parameter int unsigned LANES   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PIX_W-1:0]   a_i,
    input  logic [PIX_W-1:0]   b_i,
    input  logic [ALPHA_W-1:0] alpha_i,
    input  logic [LANES-1:0]   sgn_i,
    input  logic [1:0]         sel_i,
    input  logic               pen_i,
    input  logic               av_i,
    output logic [PIX_W-1:0]   a_q,
    output logic [PIX_W-1:0]   b_q,
    output logic [ALPHA_W-1:0] alpha_q,
    output logic [LANES-1:0]   sgn_q,
    output logic [1:0]         sel_q,
    output logic               pen_q,
    output logic               av_q
);
    localparam logic [ALPHA_W-1:0] FULL = ALPHA_W'(1) << (ALPHA_W - 1);

    logic [ALPHA_W-1:0] alpha_lim;

    // Limit the weight to full scale
    always_comb alpha_lim = (alpha_i > FULL) ? FULL : alpha_i;

    // Register every input on the same rising edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q     <= '0;
            b_q     <= '0;
            alpha_q <= '0;
            sgn_q   <= '0;
            sel_q   <= '0;
            pen_q   <= 1'b0;
            av_q    <= 1'b0;
        end else begin
            a_q     <= a_i;
            b_q     <= b_i;
            alpha_q <= alpha_lim;
            sgn_q   <= sgn_i;
            sel_q   <= sel_i;
            pen_q   <= pen_i;
            av_q    <= av_i;
        end
    end
endmodule

// File: rtl/amx_delay.sv
// Reset-to-zero shift register that delays a bundle by DEPTH clocks.
// Assumes: DEPTH >= 1.
module amx_delay #(
    parameter int unsigned W     = 8,
    parameter int unsigned DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] d_o
);
    logic [W-1:0] sr [DEPTH];

    // Shift the bundle one stage per clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(DEPTH); i++) sr[i] <= '0;
        end else begin
            sr[0] <= d_i;
            for (int i = 1; i < int'(DEPTH); i++) sr[i] <= sr[i-1];
        end
    end

    assign d_o = sr[DEPTH-1];
endmodule

// File: rtl/amx_lane.sv
// One blend lane: registers the weighted difference w*(A-B), then forms
// B + round-half-up(product / 2^FRAC) and limits it to the lane's range.
// The result is combinational off the product register; the caller registers it.
// Assumes: weight already clamped to 0..2^FRAC; inputs come from a register.
module amx_lane #(
    parameter int unsigned LANE_W  = 8,
    parameter int unsigned ALPHA_W = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LANE_W-1:0]  a_i,
    input  logic [LANE_W-1:0]  b_i,
    input  logic [ALPHA_W-1:0] alpha_i,
    input  logic               sgn_i,
    output logic [LANE_W-1:0]  res_o
);
    localparam int unsigned EXT    = LANE_W + 2;
    localparam int unsigned FRAC   = ALPHA_W - 1;
    localparam int unsigned PROD_W = EXT + ALPHA_W + 2;
    localparam logic signed [PROD_W-1:0] HALF  = PROD_W'(1) <<< (FRAC - 1);
    localparam logic signed [PROD_W-1:0] U_MAX = PROD_W'((1 << LANE_W) - 1);
    localparam logic signed [PROD_W-1:0] S_MAX = PROD_W'((1 << (LANE_W - 1)) - 1);
    localparam logic signed [PROD_W-1:0] S_MIN = -(PROD_W'(1) <<< (LANE_W - 1));

    logic signed [EXT-1:0]    a_x, b_x, diff;
    logic signed [ALPHA_W:0]  w_s;
    logic signed [PROD_W-1:0] prod_d, prod_q;
    logic signed [EXT-1:0]    b_q;
    logic                     sgn_q;
    logic signed [PROD_W-1:0] rnd, sum, lo, hi, lim;

    // Extend both operands by the lane's number format and take the difference
    always_comb begin
        a_x    = sgn_i ? {{2{a_i[LANE_W-1]}}, a_i} : {2'b00, a_i};
        b_x    = sgn_i ? {{2{b_i[LANE_W-1]}}, b_i} : {2'b00, b_i};
        diff   = a_x - b_x;
        w_s    = {1'b0, alpha_i};
        prod_d = PROD_W'(diff) * PROD_W'(w_s);
    end

    // Product stage register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_q <= '0;
            b_q    <= '0;
            sgn_q  <= 1'b0;
        end else begin
            prod_q <= prod_d;
            b_q    <= b_x;
            sgn_q  <= sgn_i;
        end
    end

    // Round half up, add B back and limit to the lane's range
    always_comb begin
        rnd = (prod_q + HALF) >>> FRAC;
        sum = rnd + PROD_W'(b_q);
        lo  = sgn_q ? S_MIN : '0;
        hi  = sgn_q ? S_MAX : U_MAX;
        if (sum < lo)      lim = lo;
        else if (sum > hi) lim = hi;
        else               lim = sum;
        res_o = lim[LANE_W-1:0];
    end
endmodule

// File: rtl/amx_out_stage.sv
// Output register: picks A, B or the blended pixel, forcing B when
// pass-enable is low, and registers the aligned qualifiers.
// Assumes: all inputs are aligned to the same pixel.
module amx_out_stage #(
    parameter int unsigned PIX_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIX_W-1:0] a_i,
    input  logic [PIX_W-1:0] b_i,
    input  logic [PIX_W-1:0] mix_i,
    input  logic [1:0]       sel_i,
    input  logic             pen_i,
    input  logic             av_i,
    output logic [PIX_W-1:0] pix_o,
    output logic             pen_o,
    output logic             av_o
);
    import amx_pkg::*;

    logic [PIX_W-1:0] pick;

    // Source select with the pass-enable override
    always_comb begin
        if (!pen_i) begin
            pick = b_i;
        end else begin
            unique case (out_sel_e'(sel_i))
                SEL_SRC_A: pick = a_i;
                SEL_SRC_B: pick = b_i;
                default:   pick = mix_i;
            endcase
        end
    end

    // Register the output word and its qualifiers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_o <= '0;
            pen_o <= 1'b0;
            av_o  <= 1'b0;
        end else begin
            pix_o <= pick;
            pen_o <= pen_i;
            av_o  <= av_i;
        end
    end
endmodule

// File: rtl/alpha_pix_mixer.sv
// Alpha-weighted pixel mixer top. Pipeline: capture -> per-lane product ->
// blend, select and output register (three registers end to end).
// Assumes: A and B are already in the same colour format.
module alpha_pix_mixer #(
    parameter int unsigned LANE_W  = 8,
    parameter int unsigned LANES   = 3,
    parameter int unsigned ALPHA_W = 9
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [LANE_W*LANES-1:0]   pix_a_i,
    input  logic [LANE_W*LANES-1:0]   pix_b_i,
    input  logic [ALPHA_W-1:0]        alpha_i,
    input  logic [LANES-1:0]          lane_signed_i,
    input  logic [1:0]                out_sel_i,
    input  logic                      pass_en_i,
    input  logic                      act_vid_i,
    output logic [LANE_W*LANES-1:0]   pix_o,
    output logic                      pass_en_o,
    output logic                      act_vid_o
);
    localparam int unsigned PIX_W  = LANE_W * LANES;
    localparam int unsigned SIDE_W = 2 * PIX_W + 4;

    logic [PIX_W-1:0]   s1_a, s1_b;
    logic [ALPHA_W-1:0] s1_alpha;
    logic [LANES-1:0]   s1_sgn;
    logic [1:0]         s1_sel;
    logic               s1_pen, s1_av;

    logic [SIDE_W-1:0]  s2_side;
    logic [PIX_W-1:0]   s2_a, s2_b, s2_mix;
    logic [1:0]         s2_sel;
    logic               s2_pen, s2_av;

    amx_capture #(
        .PIX_W   (PIX_W),
        .ALPHA_W (ALPHA_W),
        .LANES   (LANES)
    ) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_i     (pix_a_i),
        .b_i     (pix_b_i),
        .alpha_i (alpha_i),
        .sgn_i   (lane_signed_i),
        .sel_i   (out_sel_i),
        .pen_i   (pass_en_i),
        .av_i    (act_vid_i),
        .a_q     (s1_a),
        .b_q     (s1_b),
        .alpha_q (s1_alpha),
        .sgn_q   (s1_sgn),
        .sel_q   (s1_sel),
        .pen_q   (s1_pen),
        .av_q    (s1_av)
    );

    // One blend lane per component
    for (genvar g = 0; g < int'(LANES); g++) begin : g_lane
        amx_lane #(
            .LANE_W  (LANE_W),
            .ALPHA_W (ALPHA_W)
        ) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .a_i     (s1_a[g*LANE_W +: LANE_W]),
            .b_i     (s1_b[g*LANE_W +: LANE_W]),
            .alpha_i (s1_alpha),
            .sgn_i   (s1_sgn[g]),
            .res_o   (s2_mix[g*LANE_W +: LANE_W])
        );
    end

    // Carry the raw pixels and controls alongside the product stage
    amx_delay #(
        .W     (SIDE_W),
        .DEPTH (1)
    ) u_side_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({s1_a, s1_b, s1_sel, s1_pen, s1_av}),
        .d_o   (s2_side)
    );

    assign {s2_a, s2_b, s2_sel, s2_pen, s2_av} = s2_side;

    amx_out_stage #(
        .PIX_W (PIX_W)
    ) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .a_i   (s2_a),
        .b_i   (s2_b),
        .mix_i (s2_mix),
        .sel_i (s2_sel),
        .pen_i (s2_pen),
        .av_i  (s2_av),
        .pix_o (pix_o),
        .pen_o (pass_en_o),
        .av_o  (act_vid_o)
    );
endmodule

// File: rtl/amx_checker.sv
// Checker for alpha_pix_mixer: relates outputs to the inputs sampled three
// edges earlier. Active only once three edges have passed since reset.
module amx_checker #(
    parameter int unsigned PIX_W   = 24,
    parameter int unsigned ALPHA_W = 9
) (
    input logic               clk,
    input logic               rst_n,
    input logic [PIX_W-1:0]   pix_a_i,
    input logic [PIX_W-1:0]   pix_b_i,
    input logic [ALPHA_W-1:0] alpha_i,
    input logic [1:0]         out_sel_i,
    input logic               pass_en_i,
    input logic               act_vid_i,
    input logic [PIX_W-1:0]   pix_o,
    input logic               pass_en_o,
    input logic               act_vid_o
);
    logic [1:0] warm;

    // Count edges since reset, up to the pipeline depth
    always_ff @(posedge clk) begin
        if (!rst_n)             warm <= '0;
        else if (warm != 2'd3)  warm <= warm + 2'd1;
    end

    AST_QUAL_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd3) |-> (pass_en_o == $past(pass_en_i, 3) && act_vid_o == $past(act_vid_i, 3))); // R8

    AST_PASS_FORCES_B: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd3 && !pass_en_o) |-> (pix_o == $past(pix_b_i, 3))); // R7

    AST_SEL_A: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd3 && pass_en_o && $past(out_sel_i, 3) == 2'b01) |-> (pix_o == $past(pix_a_i, 3))); // R6

    AST_ZERO_WEIGHT_B: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd3 && pass_en_o && !$past(out_sel_i[0], 3) && !$past(out_sel_i[1], 3)
         && $past(alpha_i, 3) == '0) |-> (pix_o == $past(pix_b_i, 3))); // R2
endmodule

bind alpha_pix_mixer amx_checker #(
    .PIX_W   (LANE_W * LANES),
    .ALPHA_W (ALPHA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pix_a_i   (pix_a_i),
    .pix_b_i   (pix_b_i),
    .alpha_i   (alpha_i),
    .out_sel_i (out_sel_i),
    .pass_en_i (pass_en_i),
    .act_vid_i (act_vid_i),
    .pix_o     (pix_o),
    .pass_en_o (pass_en_o),
    .act_vid_o (act_vid_o)
);

// File: tb/alpha_pix_mixer_tb.sv
// Directed bench for alpha_pix_mixer: one task per scenario.
module alpha_pix_mixer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] pix_a_i = '0, pix_b_i = '0;
    logic [8:0]  alpha_i = '0;
    logic [2:0]  lane_signed_i = '0;
    logic [1:0]  out_sel_i = '0;
    logic        pass_en_i = 1'b0, act_vid_i = 1'b0;
    logic [23:0] pix_o;
    logic        pass_en_o, act_vid_o;

    int n_vec = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    alpha_pix_mixer u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .pix_a_i       (pix_a_i),
        .pix_b_i       (pix_b_i),
        .alpha_i       (alpha_i),
        .lane_signed_i (lane_signed_i),
        .out_sel_i     (out_sel_i),
        .pass_en_i     (pass_en_i),
        .act_vid_i     (act_vid_i),
        .pix_o         (pix_o),
        .pass_en_o     (pass_en_o),
        .act_vid_o     (act_vid_o)
    );

    // Independent lane model from the requirement formula
    function automatic logic [7:0] lane_ref(logic [7:0] a, logic [7:0] b, int w, bit sgn);
        int ai, bi, num, q, r;
        if (w > 256) w = 256;
        ai  = sgn ? int'($signed(a)) : int'(a);
        bi  = sgn ? int'($signed(b)) : int'(b);
        num = w * (ai - bi) + 128;
        q   = num / 256;
        if (num < 0 && (num % 256) != 0) q = q - 1;
        r = bi + q;
        if (sgn) begin
            if (r < -128) r = -128;
            if (r > 127)  r = 127;
        end else begin
            if (r < 0)   r = 0;
            if (r > 255) r = 255;
        end
        return 8'(r);
    endfunction

    function automatic logic [23:0] pix_ref(logic [23:0] a, logic [23:0] b, int w, logic [2:0] sgn);
        logic [23:0] o;
        for (int k = 0; k < 3; k++) o[k*8 +: 8] = lane_ref(a[k*8 +: 8], b[k*8 +: 8], w, sgn[k]);
        return o;
    endfunction

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic drive(logic [23:0] a, logic [23:0] b, logic [8:0] w,
                         logic [2:0] sgn, logic [1:0] sel, logic pen, logic av);
        pix_a_i = a; pix_b_i = b; alpha_i = w;
        lane_signed_i = sgn; out_sel_i = sel; pass_en_i = pen; act_vid_i = av;
    endtask

    // Drive on a falling edge, compare after the third rising edge
    task automatic one_pixel(string req, logic [23:0] a, logic [23:0] b, logic [8:0] w,
                             logic [2:0] sgn, logic [1:0] sel, logic pen, logic [23:0] exp);
        drive(a, b, w, sgn, sel, pen, 1'b1);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(req, 32'(pix_o), 32'(exp));
    endtask

    task automatic t_reset();
        drive(24'h123456, 24'h654321, 9'h080, 3'b000, 2'b01, 1'b1, 1'b1);
        repeat (4) @(negedge clk);
        check("R9 pix", 32'(pix_o), 32'h0);
        check("R9 flags", {30'h0, pass_en_o, act_vid_o}, 32'h0);
        rst_n = 1'b1;
    endtask

    task automatic t_blend_examples();
        one_pixel("R1 w=040", 24'hBBCCAA, 24'hEEFFDD, 9'h040, 3'b000, 2'b00, 1'b1, 24'hE1F2D0);
        one_pixel("R1 w=080", 24'hBBCCAA, 24'hEEFFDD, 9'h080, 3'b000, 2'b00, 1'b1, 24'hD5E6C4);
        one_pixel("R2 w=000", 24'hBBCCAA, 24'hEEFFDD, 9'h000, 3'b000, 2'b00, 1'b1, 24'hEEFFDD);
        one_pixel("R2 w=100", 24'hBBCCAA, 24'hEEFFDD, 9'h100, 3'b000, 2'b00, 1'b1, 24'hBBCCAA);
        one_pixel("R1 half up", 24'h020000, 24'h010000, 9'h080, 3'b000, 2'b00, 1'b1, 24'h020000);
    endtask

    task automatic t_clamp();
        one_pixel("R3 w=101", 24'h10E080, 24'hF02070, 9'h101, 3'b000, 2'b00, 1'b1, 24'h10E080);
        one_pixel("R3 w=1FF", 24'h10E080, 24'hF02070, 9'h1FF, 3'b000, 2'b00, 1'b1, 24'h10E080);
    endtask

    task automatic t_lanes();
        logic [23:0] a, b;
        a = 24'h00FF37; b = 24'hFF0081;
        one_pixel("R4 mixed lanes", a, b, 9'h0C3, 3'b000, 2'b00, 1'b1, pix_ref(a, b, 9'h0C3, 3'b000));
        a = 24'h00FF00; b = 24'h00FF00;
        one_pixel("R4 lane isolation", 24'h00FFFF, b, 9'h100, 3'b000, 2'b00, 1'b1, 24'h00FFFF);
        for (int i = 0; i < 6; i++) begin
            a = 24'(32'h9E3779B9 * (i + 1));
            b = 24'(32'h7F4A7C15 * (i + 3));
            one_pixel("R4 sweep", a, b, 9'(i * 47), 3'b000, 2'b11, 1'b1, pix_ref(a, b, i * 47, 3'b000));
        end
    endtask

    task automatic t_signed();
        one_pixel("R5 mixed sign w=080", 24'h808080, 24'h7F7F7F, 9'h080, 3'b101, 2'b00, 1'b1, 24'h008000);
        one_pixel("R5 mixed sign w=040", 24'h808080, 24'h7F7F7F, 9'h040, 3'b010, 2'b00, 1'b1, 24'h7F3F7F);
        for (int i = 0; i < 5; i++) begin
            logic [23:0] a, b;
            a = 24'(32'hC13FA9A9 * (i + 7));
            b = 24'(32'h6A09E667 * (i + 2));
            one_pixel("R5 signed sweep", a, b, 9'(i * 61), 3'b111, 2'b00, 1'b1, pix_ref(a, b, i * 61, 3'b111));
        end
    endtask

    task automatic t_select();
        one_pixel("R6 sel A", 24'h112233, 24'h445566, 9'h000, 3'b000, 2'b01, 1'b1, 24'h112233);
        one_pixel("R6 sel B", 24'h112233, 24'h445566, 9'h100, 3'b000, 2'b10, 1'b1, 24'h445566);
        one_pixel("R6 sel 11 blend", 24'hBBCCAA, 24'hEEFFDD, 9'h040, 3'b000, 2'b11, 1'b1, 24'hE1F2D0);
    endtask

    task automatic t_pass();
        one_pixel("R7 pass low sel A", 24'h112233, 24'h445566, 9'h100, 3'b000, 2'b01, 1'b0, 24'h445566);
        one_pixel("R7 pass low blend", 24'h112233, 24'h445566, 9'h100, 3'b000, 2'b00, 1'b0, 24'h445566);
        check("R7 pass flag", 32'(pass_en_o), 32'h0);
    endtask

    // Back-to-back pixels: each output is compared three falling edges later
    task automatic t_stream();
        logic [23:0] ea [10];
        logic        ep [10], ev [10];
        for (int i = 0; i < 13; i++) begin
            if (i >= 3) begin
                check("R8 stream pix", 32'(pix_o), 32'(ea[i-3]));
                check("R8 stream flags", {30'h0, pass_en_o, act_vid_o}, {30'h0, ep[i-3], ev[i-3]});
            end
            if (i < 10) begin
                logic [23:0] a, b;
                a = 24'(32'h2545F491 * (i + 5));
                b = 24'(32'h3C6EF372 * (i + 9));
                ep[i] = (i % 3) != 1;
                ev[i] = (i % 2) == 0;
                ea[i] = ep[i] ? pix_ref(a, b, i * 29, 3'b010) : b;
                drive(a, b, 9'(i * 29), 3'b010, 2'b00, ep[i], ev[i]);
            end
            @(negedge clk);
        end
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_blend_examples();
        t_clamp();
        t_lanes();
        t_signed();
        t_select();
        t_pass();
        t_stream();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(8 * 20000);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule